// File: doc/BRIEF.md
# Message RAM parity error logger

This block watches every word read out of a message memory and checks it against the parity bit stored with it. The memory holds up to 128 message objects of five 32-bit words each. Each read presents four things: the word data, its stored parity bit, the message object number and the word index.

A message access is framed by a start strobe and an end strobe. Within that frame the block remembers the highest-numbered word that failed its check. At the end strobe it commits that word number, and the message number that came with it, into an error code register. The same commit raises a sticky error flag and gives a one-cycle pulse.

Software reads both registers through a simple strobe-and-address port that answers one cycle later. Reading the status register clears the flag. The code register keeps the last logged code until power-on reset, and a soft reset does not touch it.

Top module: `parity_err_logger`

## Requirements
- R1: A word is failing when `rd_vld` is high and the XOR of its 32 data bits differs from `rd_par` (even parity). Words with `rd_vld` low are never checked.
- R2: A committed error sets the error flag, which is bit 0 of the status register at address 0x10. Only a status read, a soft reset or a power-on reset clears the flag. A status read returns the flag value from before the read, then clears it.
- R3: The code register reads at address 0x1C. Bits 10:8 hold the logged word number, bits 7:0 hold the logged message number, and bits 31:11 always read 0.
- R4: Within one access (from `acc_start` to `acc_end`, both cycles included), the word number committed is the highest failing one. The message number committed is the one presented with that word.
- R5: An access with no failing word leaves the code register and the flag unchanged and produces no pulse.
- R6: After `por_n` is asserted, the code register and the flag read 0. A soft reset (`soft_rst_n` low for one cycle) leaves the code register unchanged.
- R7: `err_pulse` is high for exactly the one cycle after each `acc_end` cycle that commits an error, and it is low at all other times.
- R8: If a commit and a status read fall in the same cycle, the read returns the old flag value and the flag is 1 afterwards.
- R9: `reg_rdata` shows the addressed register one cycle after `reg_rd`. Any other address reads 0, and `reg_rdata` is 0 in cycles that follow no read.
- R10: A soft reset clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset; clears all state |
| soft_rst_n | input | 1 | Synchronous active-low soft reset; clears the flag only |
| rd_vld | input | 1 | A memory word is presented this cycle |
| rd_data | input | 32 | Word data |
| rd_par | input | 1 | Stored parity bit of the word |
| rd_msg | input | 8 | Message object number (1 to 128) |
| rd_word | input | 3 | Word index within the object (1 to 5) |
| acc_start | input | 1 | First cycle of a message access |
| acc_end | input | 1 | Last cycle of a message access |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register read address |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| err_pulse | output | 1 | One-cycle pulse per committed error |

## Verification
Two events can land on the same clock edge: an access-end commit that sets the flag, and a status read that clears it. The bench provokes this by raising the status read strobe in the very cycle that carries `acc_end` on a failing access. It does so once with the flag already set and once with it clear. Each time it checks that the returned value is the flag from before that edge, and that a following status read sees 1.

// File: rtl/parlog_pkg.sv
package parlog_pkg;
  localparam int MSG_W  = 8;
  localparam int WORD_W = 3;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [MSG_W-1:0]  msg;
  } code_t;

  localparam int CODE_W = $bits(code_t);
endpackage

// File: rtl/parlog_par_check.sv
module parlog_par_check #(
  parameter int DATA_W = 32
) (
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              bad
);
  logic calc_par;

  always_comb begin
    calc_par = ^data;
    bad      = vld & (calc_par ^ par);
  end
endmodule

// File: rtl/parlog_collect.sv
module parlog_collect
  import parlog_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              bad,
  input  logic [MSG_W-1:0]  msg,
  input  logic [WORD_W-1:0] word,
  input  logic              acc_start,
  input  logic              acc_end,
  output logic              commit,
  output code_t             commit_code
);
  logic              grp_hit_q, grp_hit_d;
  code_t             grp_q, grp_d;
  logic              base_hit;
  code_t             base;
  logic              take;

  always_comb begin
    base_hit = acc_start ? 1'b0 : grp_hit_q;
    base     = acc_start ? '0   : grp_q;
    take     = bad && (!base_hit || (word > base.word));
    grp_d    = base;
    if (take) begin
      grp_d.word = word;
      grp_d.msg  = msg;
    end
    grp_hit_d   = base_hit | bad;
    commit      = acc_end & grp_hit_d;
    commit_code = grp_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      grp_hit_q <= 1'b0;
      grp_q     <= '0;
    end else begin
      grp_hit_q <= acc_end ? 1'b0 : grp_hit_d;
      grp_q     <= acc_end ? '0   : grp_d;
    end
  end
endmodule

// File: rtl/parlog_regs.sv
module parlog_regs
  import parlog_pkg::*;
#(
  parameter int                RD_W      = 32,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 8'h1C,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic              commit,
  input  code_t             commit_code,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [RD_W-1:0]   reg_rdata,
  output logic              err_pulse,
  output logic              flag,
  output code_t             code
);
  logic            flag_d, pulse_d, stat_rd;
  code_t           code_d;
  logic [RD_W-1:0] rdata_d;

  always_comb begin
    stat_rd = reg_rd && (reg_addr == STAT_ADDR);
    if (!soft_rst_n)  flag_d = 1'b0;
    else if (commit)  flag_d = 1'b1;
    else if (stat_rd) flag_d = 1'b0;
    else              flag_d = flag;
    code_d  = commit ? commit_code : code;
    pulse_d = commit;
    rdata_d = '0;
    if (reg_rd) begin
      if (reg_addr == CODE_ADDR)      rdata_d = {{(RD_W-CODE_W){1'b0}}, code};
      else if (reg_addr == STAT_ADDR) rdata_d = {{(RD_W-1){1'b0}}, flag};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag      <= 1'b0;
      code      <= '0;
      err_pulse <= 1'b0;
      reg_rdata <= '0;
    end else begin
      flag      <= flag_d;
      code      <= code_d;
      err_pulse <= pulse_d;
      reg_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/parity_err_logger.sv
module parity_err_logger
  import parlog_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                RD_W      = 32,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 8'h1C,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_par,
  input  logic [MSG_W-1:0]  rd_msg,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              acc_start,
  input  logic              acc_end,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [RD_W-1:0]   reg_rdata,
  output logic              err_pulse
);
  logic  bad;
  logic  commit;
  code_t commit_code;
  logic  flag;
  code_t code;

  parlog_par_check #(.DATA_W(DATA_W)) u_par (
    .vld(rd_vld), .data(rd_data), .par(rd_par), .bad(bad)
  );

  parlog_collect u_col (
    .clk(clk), .por_n(por_n), .bad(bad), .msg(rd_msg), .word(rd_word),
    .acc_start(acc_start), .acc_end(acc_end),
    .commit(commit), .commit_code(commit_code)
  );

  parlog_regs #(
    .RD_W(RD_W), .ADDR_W(ADDR_W), .CODE_ADDR(CODE_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n),
    .commit(commit), .commit_code(commit_code),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .err_pulse(err_pulse), .flag(flag), .code(code)
  );
endmodule

// File: rtl/parlog_chk.sv
module parlog_chk
  import parlog_pkg::*;
#(
  parameter int                RD_W      = 32,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
  input logic              clk,
  input logic              por_n,
  input logic              soft_rst_n,
  input logic              commit,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [RD_W-1:0]   reg_rdata,
  input logic              err_pulse,
  input logic              flag,
  input code_t             code
);
  logic stat_rd;
  assign stat_rd = reg_rd && (reg_addr == STAT_ADDR);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (flag && !stat_rd && soft_rst_n) |=> flag);                          // R2
  AST_FLAG_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!por_n)
    (stat_rd && !commit && soft_rst_n) |=> !flag);                       // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[RD_W-1:CODE_W] == '0);                                     // R3
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !commit |=> $stable(code));                                          // R6
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    (commit && soft_rst_n) |=> (err_pulse && flag));                     // R7
  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    !commit |=> !err_pulse);                                             // R7
  AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!por_n)
    (commit && stat_rd && soft_rst_n) |=> flag);                         // R8
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!por_n)
    !reg_rd |=> (reg_rdata == '0));                                      // R9
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    !soft_rst_n |=> !flag);                                              // R10
endmodule

bind parity_err_logger parlog_chk #(
  .RD_W(RD_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .commit(commit),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .err_pulse(err_pulse), .flag(flag), .code(code)
);

// File: tb/parity_err_logger_tb.sv
module parity_err_logger_tb;
  localparam logic [7:0] CODE_A = 8'h1C;
  localparam logic [7:0] STAT_A = 8'h10;

  logic        clk = 1'b0;
  logic        por_n, soft_rst_n, rd_vld, rd_par, acc_start, acc_end, reg_rd;
  logic [31:0] rd_data, reg_rdata;
  logic [7:0]  rd_msg, reg_addr;
  logic [2:0]  rd_word;
  logic        err_pulse;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic       m_flag;
  logic [2:0] m_word;
  logic [7:0] m_msg;

  always #5 clk = ~clk;

  parity_err_logger u_dut (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .rd_vld(rd_vld),
    .rd_data(rd_data), .rd_par(rd_par), .rd_msg(rd_msg), .rd_word(rd_word),
    .acc_start(acc_start), .acc_end(acc_end), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .err_pulse(err_pulse)
  );

  function automatic logic [31:0] exp_code(logic [2:0] w, logic [7:0] m);
    return {21'b0, w, m};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_vld = 0; rd_data = '0; rd_par = 0; rd_msg = '0; rd_word = '0;
    acc_start = 0; acc_end = 0; reg_rd = 0; reg_addr = '0; soft_rst_n = 1;
  endtask

  task automatic do_read(logic [7:0] addr, output logic [31:0] val);
    reg_rd = 1; reg_addr = addr;
    @(negedge clk);
    reg_rd = 0; reg_addr = '0;
    val = reg_rdata;
  endtask

  // One access of nw words on message msg; bad_mask bit k marks word k+1 as corrupt.
  // stat_at_end raises a status read in the acc_end cycle. vld_mask bit k low
  // presents word k+1 with rd_vld low.
  task automatic do_access(logic [7:0] msg, int nw, logic [4:0] bad_mask,
                           logic [4:0] vld_mask, bit stat_at_end, string req);
    logic [2:0] hi_w = 3'd0;
    logic       old_flag = m_flag;
    logic [31:0] got;
    for (int k = 0; k < nw; k++) begin
      rd_vld    = vld_mask[k];
      rd_data   = $urandom;
      rd_par    = (^rd_data) ^ bad_mask[k];
      rd_msg    = msg;
      rd_word   = 3'(k + 1);
      acc_start = (k == 0);
      acc_end   = (k == nw - 1);
      if (bad_mask[k] && vld_mask[k]) hi_w = 3'(k + 1);
      if (stat_at_end && k == nw - 1) begin reg_rd = 1; reg_addr = STAT_A; end
      @(negedge clk);
      if (k != nw - 1) check("R7", {31'b0, err_pulse}, 32'd0);
    end
    got = reg_rdata;
    idle();
    check(req, {31'b0, err_pulse}, {31'b0, (hi_w != 0)});
    if (stat_at_end) begin
      check("R8", got, {31'b0, old_flag});
      m_flag = 1'b0;
    end
    if (hi_w != 0) begin
      m_flag = 1'b1; m_word = hi_w; m_msg = msg;
    end
  endtask

  task automatic chk_regs(string req);
    logic [31:0] v;
    do_read(CODE_A, v);
    check(req, v, exp_code(m_word, m_msg));
    do_read(STAT_A, v);
    check(req, v, {31'b0, m_flag});
    m_flag = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    idle();
    por_n = 0; m_flag = 0; m_word = 0; m_msg = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    check("R9", reg_rdata, 32'd0);
    chk_regs("R6");

    // R4 directed: words 2 and 4 bad -> word 4
    do_access(8'd7, 5, 5'b01010, 5'b11111, 0, "R4");
    chk_regs("R4");
    // R1 directed: corrupt word with rd_vld low is not checked
    do_access(8'd9, 3, 5'b00100, 5'b11011, 0, "R1");
    chk_regs("R1");
    // R5: clean access keeps code
    do_access(8'd20, 5, 5'b00000, 5'b11111, 0, "R5");
    chk_regs("R5");
    // R3 boundary: message 128, word 5
    do_access(8'd128, 5, 5'b10001, 5'b11111, 0, "R3");
    chk_regs("R3");
    // R9: unmapped address reads zero
    do_read(8'h44, v);
    check("R9", v, 32'd0);
    // R2: stickiness across clean accesses and code reads
    do_access(8'd3, 2, 5'b00001, 5'b11111, 0, "R7");
    do_access(8'd4, 5, 5'b00000, 5'b11111, 0, "R5");
    do_read(CODE_A, v);
    check("R2", v, exp_code(m_word, m_msg));
    do_read(STAT_A, v);
    check("R2", v, 32'd1);
    m_flag = 0;
    do_read(STAT_A, v);
    check("R2", v, 32'd0);
    // R8: collision with flag clear, then with flag set
    do_access(8'd50, 4, 5'b00010, 5'b11111, 1, "R8");
    do_access(8'd51, 3, 5'b00100, 5'b11111, 1, "R8");
    chk_regs("R8");
    // R10 / R6: soft reset clears flag, keeps code
    do_access(8'd77, 5, 5'b00100, 5'b11111, 0, "R7");
    soft_rst_n = 0;
    @(negedge clk);
    soft_rst_n = 1;
    m_flag = 0;
    do_read(STAT_A, v);
    check("R10", v, 32'd0);
    do_read(CODE_A, v);
    check("R6", v, exp_code(3'd3, 8'd77));

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] bm = 5'($urandom) & 5'($urandom);
      do_access(8'($urandom_range(128, 1)), $urandom_range(5, 1), bm,
                ($urandom_range(7, 0) == 0) ? 5'($urandom) : 5'b11111,
                ($urandom_range(7, 0) == 0), "R4");
      if ($urandom_range(3, 0) == 0) chk_regs("R2");
    end
    chk_regs("R4");

    // R6: power-on reset clears code
    por_n = 0;
    @(negedge clk);
    por_n = 1;
    m_flag = 0; m_word = 0; m_msg = 0;
    @(negedge clk);
    chk_regs("R6");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule